// File: doc/BRIEF.md
# Sticky Out-of-Lock Fault Latch

This block watches the lock-detect output of a frequency synthesizer loop and remembers any loss of lock. The latch arms and clears on the strobe that commits a new divider setting. Once armed, any sampled low on lock detect sets a fault that stays set until the next commit strobe, even if lock returns. Lock detect arrives from another clock domain, so it passes through a flip-flop synchronizer before the latch looks at it.

The fault is reported only while the oscillator is enabled, which happens when the active-low key line is low. It goes to two outputs with opposite polarity: an active-low status flag for external monitoring and an active-high drive for a front-panel indicator lamp. While the key line is high both outputs show "no fault", but the latch keeps its state. When the key line falls again, a fault stored earlier appears at once.

Top module: `lock_fault_mon`

## Requirements
- R1: While `rst_n` is low at a clock edge, the latch is cleared, the block becomes unarmed and the synchronizer stages load the locked value 1. After reset, `flag_n` is 1 and `lamp_on` is 0.
- R2: Before the first commit strobe after reset, a low on `lock_det` never sets the fault.
- R3: Once armed, a low on `lock_det` held for one full clock period sets the fault. The fault is visible after the third rising edge that samples the low (two synchronizer stages plus the latch).
- R4: A set fault stays set when `lock_det` returns high, for as long as no commit strobe comes.
- R5: A high `commit` at a clock edge clears the fault and arms the latch from that edge onward.
- R6: If `commit` is high at the same edge where a synchronized low lock detect would set the fault, the clear wins. A low that is still present sets the fault at a later edge.
- R7: With `key_n` low, `flag_n` is 0 and `lamp_on` is 1 exactly when the fault is set. `key_n` acts combinationally, with no clock delay.
- R8: With `key_n` high, `flag_n` is 1 and `lamp_on` is 0, but the stored fault is kept and shows again when `key_n` returns low.
- R9: `lamp_on` is always the inverse of `flag_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_det | input | 1 | Lock detect from the loop, asynchronous, 1 = locked |
| commit | input | 1 | Programming commit strobe, synchronous, active high |
| key_n | input | 1 | Oscillator key line, active low enables the oscillator |
| flag_n | output | 1 | Status flag, 0 = out of lock reported |
| lamp_on | output | 1 | Indicator lamp drive, 1 = lamp lit |

## Verification
A stuck or lost fault bit shows at the outputs as soon as `key_n` is low. Either a lit lamp remains after a commit, or the lamp fails to light three edges after a dropout. An arm bit that is wrong shows up as a fault raised by a dropout before the first commit. A synchronizer of the wrong depth moves the edge on which the lamp lights, so the bench samples the edges just before and just after the required one. Hiding the fault under a high key line is checked by lowering the key again and watching the stored fault come back.

// File: rtl/lock_fault_pkg.sv
// Package: shared constants and the latch state type for the lock fault monitor.
// Assumes: nothing beyond IEEE 1800-2017.
package lock_fault_pkg;

    // Default synchronizer depth for the lock detect input.
    localparam int unsigned SYNC_DEPTH_DEF = 2;

    // Latch state: armed after the first commit, fault while out of lock.
    typedef struct packed {
        logic armed;
        logic fault;
    } latch_state_t;

endpackage

// File: rtl/lock_sync.sv
// Module: lock_sync
// Moves the asynchronous lock detect level into the clock domain through
// a chain of DEPTH flip-flops.
// Assumes: DEPTH >= 2. Reset loads the locked level 1 into every stage.
module lock_sync #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] stage;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the raw input in the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[0] <= 1'b1;
                    else        stage[0] <= din;
                end
            end else begin : g_next
                // Pass the level one stage further down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[g] <= 1'b1;
                    else        stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    assign dout = stage[DEPTH-1];
endmodule

// File: rtl/fault_latch.sv
// Module: fault_latch
// Sticky out-of-lock latch. The commit strobe arms the latch and clears it.
// While armed, a synchronized low lock detect sets the fault until the next commit.
// Assumes: ld_sync is already in the clock domain. The clear wins over a set.
module fault_latch
    import lock_fault_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ld_sync,
    input  logic commit,
    output logic fault,
    output logic armed
);
    latch_state_t st;

    // Update the arm bit and the fault bit once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '{armed: 1'b0, fault: 1'b0};
        end else if (commit) begin
            st <= '{armed: 1'b1, fault: 1'b0};
        end else if (st.armed && !ld_sync) begin
            st.fault <= 1'b1;
        end
    end

    assign fault = st.fault;
    assign armed = st.armed;

    // R2: the fault cannot be set before the latch is armed
    assert_unarmed_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !fault);

    // R3: an armed latch that sees a low without a commit reports the fault next cycle
    assert_dropout_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !ld_sync && !commit) |=> fault);

    // R4: a set fault stays set until a commit arrives
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !commit) |=> fault);

    // R5/R6: a commit always leaves the latch armed and clear
    assert_commit_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (armed && !fault));
endmodule

// File: rtl/fault_report.sv
// Module: fault_report
// Qualifies the stored fault with the oscillator enable and drives the two outputs.
// Assumes: key_n low enables the oscillator. It is combinational, so the key acts at once.
module fault_report (
    input  logic fault,
    input  logic key_n,
    output logic flag_n,
    output logic lamp_on
);
    logic osc_en;
    logic shown;

    // Derive the enable, then gate the fault with it.
    always_comb begin
        osc_en  = ~key_n;
        shown   = osc_en & fault;
        flag_n  = ~shown;
        lamp_on = shown;
    end
endmodule

// File: rtl/lock_fault_mon.sv
// Module: lock_fault_mon (top)
// Out-of-lock fault monitor: synchronizer, sticky latch and output gating.
// Assumes: commit and key_n are synchronous to clk, and lock_det is asynchronous.
module lock_fault_mon
    import lock_fault_pkg::*;
#(
    parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_det,
    input  logic commit,
    input  logic key_n,
    output logic flag_n,
    output logic lamp_on
);
    logic ld_sync;
    logic fault;
    logic armed;

    lock_sync #(.DEPTH(SYNC_DEPTH)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (lock_det),
        .dout  (ld_sync)
    );

    fault_latch i_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_sync (ld_sync),
        .commit  (commit),
        .fault   (fault),
        .armed   (armed)
    );

    fault_report i_report (
        .fault   (fault),
        .key_n   (key_n),
        .flag_n  (flag_n),
        .lamp_on (lamp_on)
    );

    // R7: with the oscillator enabled, a stored fault pulls the flag low
    assert_fault_shown_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_n && fault) |-> (!flag_n && lamp_on));

    // R8: with the oscillator disabled, the outputs report no fault
    assert_key_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        key_n |-> (flag_n && !lamp_on));

    // R9: the lamp and the flag never agree
    assert_opposite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lamp_on != flag_n);
endmodule

// File: tb/test_lock_fault_mon.sv
// Bench for lock_fault_mon: directed corner cases followed by random stimulus
// from a fixed seed, checked against a cycle model written from the requirements.
module test_lock_fault_mon;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lock_det = 1'b1;
    logic commit = 1'b0;
    logic key_n = 1'b0;
    logic flag_n;
    logic lamp_on;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;  // 250 MHz

    lock_fault_mon i_lock_fault_mon (
        .clk(clk), .rst_n(rst_n), .lock_det(lock_det), .commit(commit),
        .key_n(key_n), .flag_n(flag_n), .lamp_on(lamp_on)
    );

    // Requirement model: two sampling stages, then an arm bit and a sticky fault bit.
    logic m_s1 = 1'b1, m_s2 = 1'b1, m_armed = 1'b0, m_fault = 1'b0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 1'b1; m_s2 <= 1'b1; m_armed <= 1'b0; m_fault <= 1'b0;
        end else begin
            m_s1 <= lock_det;
            m_s2 <= m_s1;
            if (commit) begin
                m_armed <= 1'b1; m_fault <= 1'b0;
            end else if (m_armed && !m_s2) begin
                m_fault <= 1'b1;
            end
        end
    end

    function automatic bit expect_shown(input bit f, input bit k);
        return f && !k;
    endfunction

    task automatic check_out(input string tag, input bit exp_shown);
        checks++;
        if (flag_n !== !exp_shown || lamp_on !== exp_shown) begin
            failures++;
            $display("FAIL %s: flag_n=%b lamp_on=%b expected flag_n=%b lamp_on=%b",
                     tag, flag_n, lamp_on, !exp_shown, exp_shown);
        end
    endtask

    // Run one clock with the current inputs, then settle at the falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        rst_n = 1'b0; key_n = 1'b0;
        repeat (3) tick();
        check_out("R1 reset", 1'b0);
        rst_n = 1'b1;

        // R2: dropout before any commit leaves outputs clear
        lock_det = 1'b0;
        for (int i = 0; i < 6; i++) begin
            tick();
            check_out("R2 unarmed dropout", 1'b0);
        end
        lock_det = 1'b1;
        repeat (3) tick();
        check_out("R2 after dropout", 1'b0);

        // R5: commit arms without setting
        commit = 1'b1; tick(); commit = 1'b0;
        check_out("R5 commit arms clear", 1'b0);
        repeat (3) tick();

        // R3: one-period low, visible on the third edge only
        lock_det = 1'b0;
        tick(); lock_det = 1'b1;
        check_out("R3 edge1", 1'b0);
        tick();
        check_out("R3 edge2", 1'b0);
        tick();
        check_out("R3 edge3", 1'b1);

        // R4: sticky while lock_det stays high
        repeat (10) tick();
        check_out("R4 sticky", 1'b1);

        // R8: key high hides the fault, key low shows it again at once
        key_n = 1'b1; #1;
        check_out("R8 masked", 1'b0);
        repeat (4) tick();
        check_out("R8 masked held", 1'b0);
        key_n = 1'b0; #1;
        check_out("R8 reappears", 1'b1);
        // R7: the key acts with no clock delay
        key_n = 1'b1; #1;
        check_out("R7 combinational key", 1'b0);
        key_n = 1'b0; #1;

        // R5: commit clears the fault
        commit = 1'b1; tick(); commit = 1'b0;
        check_out("R5 commit clears", 1'b0);
        repeat (3) tick();
        check_out("R5 stays clear", 1'b0);

        // R6: commit while the synchronized low is present, clear wins at that edge
        lock_det = 1'b0;
        repeat (4) tick();
        check_out("R6 set before commit", 1'b1);
        commit = 1'b1; tick(); commit = 1'b0;
        check_out("R6 clear wins", 1'b0);
        tick();
        check_out("R6 low sets again", 1'b1);
        lock_det = 1'b1;
        repeat (3) tick();
        commit = 1'b1; tick(); commit = 1'b0;

        // Random phase: model-checked (R3 R4 R5 R6 R7 R8 R9)
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 3000; i++) begin
            lock_det = ($urandom % 10) != 0;
            commit   = ($urandom % 25) == 0;
            key_n    = ($urandom % 8) == 0;
            tick();
            check_out("R7 random vs model", expect_shown(m_fault, key_n));
            checks++;
            if (lamp_on === flag_n) begin
                failures++;
                $display("FAIL R9: lamp_on=%b flag_n=%b expected opposite", lamp_on, flag_n);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule